// File: doc/BRIEF.md
# Reset Source Capture Register

This block records why the chip last came out of reset. It watches six reset causes: power-on, watchdog timeout, illegal opcode, opcode fetch from an illegal address, monitor-mode entry and low voltage. It also watches an external active-low reset pin that it shares with the rest of the board. Whenever an internal cause or power-on is active, the block pulls that pin low. Once it lets go, it waits a fixed number of oscillator cycles and then checks whether something outside is still holding the pin low. If so, it adds the external-pin flag to the internal cause already recorded.

Software reads the result as one 8-bit status byte through a read strobe. The read returns the byte as it stood, and the strobe clears all flags on the following clock edge. Power-on forces the byte to hold only the power-on flag. Any other cause adds its own flag and leaves the others alone, so causes that no read has cleared build up.

Top module: `rstsrc_capture`

## Requirements
- R1: While `por_i` is high, and after it falls until another event or a read, `status_o` is 8'h80: bit 7 (power-on) set and every other bit clear.
- R2: Status bit positions: 7 power-on, 6 external pin, 5 watchdog, 4 illegal opcode, 3 illegal address, 2 monitor entry, 1 low voltage. Bit 0 always reads 0. A cause input that is high at a clock edge shows its bit set after that edge.
- R3: Bit 3 is set only when `bad_addr_i` and `opfetch_i` are both high at the same edge. An illegal address on a data access (`opfetch_i` low) leaves bit 3 clear.
- R4: A cause other than power-on sets its own bit and keeps every other bit unchanged, so several cause bits can be set together.
- R5: During the cycle in which `rd_stb_i` is high, `status_o` shows the flags as they were before the read. After that edge, all flags are 0 unless a cause is active at the same edge.
- R6: If a cause is active at the same edge as a read strobe, the flag for that cause is set after the edge, and all other flags are cleared.
- R7: `rst_drive_o` (1 = pull the pin low) is high while `por_i` is high. It rises at the first edge at which any internal cause input is high, and it falls at the first edge at which none is high.
- R8: The edge at which `rst_drive_o` falls counts as edge 0. At edge `REL_WAIT` (default 32) the synchronized pin is sampled. If it is low, bit 6 is set after that edge in addition to the internal cause. If it is high, bit 6 stays clear. The same holds after power-on ends.
- R9: While the block is not driving the pin and no release window is pending, a low level on `rst_pin_i` sets bit 6 after the third edge (two synchronizer stages, then the flag register). `rst_drive_o` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| wdog_i | input | 1 | Watchdog timeout cause |
| badop_i | input | 1 | Illegal opcode cause |
| bad_addr_i | input | 1 | Access to an illegal address |
| opfetch_i | input | 1 | Qualifies `bad_addr_i` as an opcode fetch |
| mon_i | input | 1 | Monitor-mode entry cause |
| lowv_i | input | 1 | Low-voltage cause |
| rst_pin_i | input | 1 | Level sensed on the external reset pin (0 = low) |
| rst_drive_o | output | 1 | 1 = pull the external reset pin low |
| rd_stb_i | input | 1 | CPU read strobe for the status byte |
| status_o | output | 8 | Status byte |

## Verification
Each cause flag and the drive output change at the first edge after their input is seen high, so the bench drives inputs on the falling edge and checks on the next falling edge. A read shows the old byte while the strobe is high and shows the cleared byte one edge later. The external-only flag is due at the third edge after the pin goes low, and the bench checks that it is still clear after the second. For the release window, the bench checks the pin flag just before edge 32 after release and just after it, so that an early or late sample point fails the check.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   localparam int STAT_W  = 8;
   localparam int B_PWRON = 7;
   localparam int B_XPIN  = 6;
   localparam int B_WDOG  = 5;
   localparam int B_BADOP = 4;
   localparam int B_BADAD = 3;
   localparam int B_MON   = 2;
   localparam int B_LOWV  = 1;

   typedef logic [STAT_W-1:0] stat_t;

   localparam stat_t STAT_PWRON = stat_t'(1) << B_PWRON;

   function automatic stat_t cause_mask(input logic xpin, input logic wdog,
                                        input logic badop, input logic badad,
                                        input logic mon, input logic lowv);
      stat_t m;
      m          = '0;
      m[B_XPIN]  = xpin;
      m[B_WDOG]  = wdog;
      m[B_BADOP] = badop;
      m[B_BADAD] = badad;
      m[B_MON]   = mon;
      m[B_LOWV]  = lowv;
      return m;
   endfunction
endpackage

// File: rtl/rcr_pin_sync.sv
module rcr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_i,
   input  logic pin_i,
   output logic pin_sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rcr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or posedge por_i) begin
            if (por_i) chain_q[s] <= 1'b1;
            else       chain_q[s] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge por_i) begin
            if (por_i) chain_q[s] <= 1'b1;
            else       chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign pin_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcr_release_timer.sv
module rcr_release_timer #(
   parameter int REL_WAIT = 32
) (
   input  logic clk,
   input  logic por_i,
   input  logic int_evt_i,
   input  logic pin_sync_i,
   output logic drive_o,
   output logic pin_hit_o
);
   localparam int CNT_W = (REL_WAIT > 1) ? $clog2(REL_WAIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REL_WAIT - 1);

   if (REL_WAIT < 4) begin : g_bad_wait
      $error("rcr_release_timer: REL_WAIT must be at least 4");
   end

   logic             drv_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_sample;
   logic             idle;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         drv_q   <= 1'b1;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         drv_q <= int_evt_i;
         if (int_evt_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else if (drv_q) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end else if (armed_q) begin
            if (cnt_q == LAST) armed_q <= 1'b0;
            else               cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign at_sample = armed_q && (cnt_q == LAST);
   assign idle      = !armed_q && !drv_q;
   assign drive_o   = por_i | drv_q;
   assign pin_hit_o = !pin_sync_i && (at_sample || idle);
endmodule

// File: rtl/rcr_flag_bank.sv
module rcr_flag_bank
   import rcr_pkg::*;
(
   input  logic  clk,
   input  logic  por_i,
   input  stat_t set_i,
   input  logic  clr_i,
   output stat_t flags_o
);
   stat_t flags_q;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) flags_q <= STAT_PWRON;
      else       flags_q <= (clr_i ? stat_t'(0) : flags_q) | set_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/rstsrc_capture.sv
module rstsrc_capture
   import rcr_pkg::*;
#(
   parameter int REL_WAIT    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        por_i,
   input  logic        wdog_i,
   input  logic        badop_i,
   input  logic        bad_addr_i,
   input  logic        opfetch_i,
   input  logic        mon_i,
   input  logic        lowv_i,
   input  logic        rst_pin_i,
   output logic        rst_drive_o,
   input  logic        rd_stb_i,
   output logic [7:0]  status_o
);
   if (REL_WAIT <= SYNC_STAGES) begin : g_bad_cfg
      $error("rstsrc_capture: REL_WAIT must exceed SYNC_STAGES");
   end

   logic  badad_fetch;
   logic  int_evt;
   logic  pin_sync;
   logic  pin_hit;
   stat_t set_mask;
   stat_t flags;

   assign badad_fetch = bad_addr_i & opfetch_i;
   assign int_evt     = wdog_i | badop_i | badad_fetch | mon_i | lowv_i;

   rcr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .por_i      (por_i),
      .pin_i      (rst_pin_i),
      .pin_sync_o (pin_sync)
   );

   rcr_release_timer #(.REL_WAIT(REL_WAIT)) u_timer (
      .clk        (clk),
      .por_i      (por_i),
      .int_evt_i  (int_evt),
      .pin_sync_i (pin_sync),
      .drive_o    (rst_drive_o),
      .pin_hit_o  (pin_hit)
   );

   assign set_mask = cause_mask(pin_hit, wdog_i, badop_i, badad_fetch, mon_i, lowv_i);

   rcr_flag_bank u_flags (
      .clk     (clk),
      .por_i   (por_i),
      .set_i   (set_mask),
      .clr_i   (rd_stb_i),
      .flags_o (flags)
   );

   assign status_o = flags;
endmodule

// File: rtl/rstsrc_capture_chk.sv
module rstsrc_capture_chk (
   input logic       clk,
   input logic       por_i,
   input logic       wdog_i,
   input logic       badop_i,
   input logic       bad_addr_i,
   input logic       opfetch_i,
   input logic       mon_i,
   input logic       lowv_i,
   input logic       rd_stb_i,
   input logic       rst_drive_o,
   input logic [7:0] status_o
);
   logic any_cause;
   assign any_cause = wdog_i | badop_i | (bad_addr_i & opfetch_i) | mon_i | lowv_i;

   // R1
   pwron_only_by_por_chk: assert property (@(posedge clk) disable iff (por_i)
      !$rose(status_o[7]));

   // R2
   bit0_zero_chk: assert property (@(posedge clk) disable iff (por_i)
      status_o[0] == 1'b0);

   // R3
   badad_needs_fetch_chk: assert property (@(posedge clk) disable iff (por_i)
      $rose(status_o[3]) |-> $past(bad_addr_i && opfetch_i));

   // R6
   wdog_sticks_chk: assert property (@(posedge clk) disable iff (por_i)
      wdog_i |=> status_o[5]);

   // R5
   read_clears_chk: assert property (@(posedge clk) disable iff (por_i)
      (rd_stb_i && !any_cause) |=> (status_o[7] == 1'b0 && status_o[5:0] == 6'd0));

   // R7
   drive_follows_cause_chk: assert property (@(posedge clk) disable iff (por_i)
      any_cause |=> rst_drive_o);
endmodule

bind rstsrc_capture rstsrc_capture_chk u_chk (
   .clk         (clk),
   .por_i       (por_i),
   .wdog_i      (wdog_i),
   .badop_i     (badop_i),
   .bad_addr_i  (bad_addr_i),
   .opfetch_i   (opfetch_i),
   .mon_i       (mon_i),
   .lowv_i      (lowv_i),
   .rd_stb_i    (rd_stb_i),
   .rst_drive_o (rst_drive_o),
   .status_o    (status_o)
);

// File: tb/sim_rstsrc_capture.sv
module sim_rstsrc_capture;
   logic       clk = 1'b0;
   logic       por_i = 1'b1;
   logic       wdog_i = 1'b0, badop_i = 1'b0, bad_addr_i = 1'b0, opfetch_i = 1'b0;
   logic       mon_i = 1'b0, lowv_i = 1'b0, rd_stb_i = 1'b0;
   logic       ext_low = 1'b0;
   logic       rst_pin_i;
   logic       rst_drive_o;
   logic [7:0] status_o;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   // open-drain pin: low if the block or the outside pulls it
   assign rst_pin_i = !(ext_low || rst_drive_o);

   rstsrc_capture u0 (
      .clk(clk), .por_i(por_i), .wdog_i(wdog_i), .badop_i(badop_i),
      .bad_addr_i(bad_addr_i), .opfetch_i(opfetch_i), .mon_i(mon_i),
      .lowv_i(lowv_i), .rst_pin_i(rst_pin_i), .rst_drive_o(rst_drive_o),
      .rd_stb_i(rd_stb_i), .status_o(status_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(input logic [7:0] exp);
      rd_stb_i = 1'b1;
      #1 check("R5 read value", status_o, exp);
      cyc(1);
      rd_stb_i = 1'b0;
      check("R5 cleared", status_o, 8'h00);
   endtask

   // one-cycle pulse then wait for the release window to finish
   task automatic pulse(ref logic sig);
      sig = 1'b1;
      cyc(1);
      sig = 1'b0;
      cyc(36);
   endtask

   task automatic t_por;
      por_i = 1'b1;
      cyc(3);
      check("R1 during por", status_o, 8'h80);
      check("R7 drive in por", {7'd0, rst_drive_o}, 8'h01);
      por_i = 1'b0;
      cyc(36);
      check("R1 after por", status_o, 8'h80);
      check("R8 no pin flag after por", status_o & 8'h40, 8'h00);
      do_read(8'h80);
   endtask

   task automatic t_sources;
      wdog_i = 1'b1;
      cyc(1);
      check("R2 wdog bit5", status_o, 8'h20);
      check("R7 drive rises", {7'd0, rst_drive_o}, 8'h01);
      wdog_i = 1'b0;
      cyc(1);
      check("R7 drive falls", {7'd0, rst_drive_o}, 8'h00);
      cyc(35);
      do_read(8'h20);
      pulse(badop_i);
      do_read(8'h10);
      pulse(mon_i);
      do_read(8'h04);
      pulse(lowv_i);
      check("R2 lowv bit1 bit0 zero", status_o, 8'h02);
      do_read(8'h02);
   endtask

   task automatic t_badaddr;
      bad_addr_i = 1'b1; opfetch_i = 1'b0;
      cyc(1);
      check("R3 data access ignored", status_o, 8'h00);
      check("R3 no drive on data access", {7'd0, rst_drive_o}, 8'h00);
      opfetch_i = 1'b1;
      cyc(1);
      check("R3 fetch sets bit3", status_o, 8'h08);
      bad_addr_i = 1'b0; opfetch_i = 1'b0;
      cyc(36);
      do_read(8'h08);
   endtask

   task automatic t_accum;
      pulse(wdog_i);
      pulse(lowv_i);
      pulse(badop_i);
      check("R4 accumulate", status_o, 8'h32);
      do_read(8'h32);
   endtask

   task automatic t_collide;
      pulse(mon_i);
      lowv_i = 1'b1; rd_stb_i = 1'b1;
      #1 check("R5 pre-clear value", status_o, 8'h04);
      cyc(1);
      lowv_i = 1'b0; rd_stb_i = 1'b0;
      check("R6 event wins", status_o, 8'h02);
      cyc(36);
      do_read(8'h02);
   endtask

   task automatic t_window_low;
      wdog_i = 1'b1; ext_low = 1'b1;
      cyc(1);
      wdog_i = 1'b0;
      cyc(32);
      check("R8 not yet at edge 31", status_o, 8'h20);
      cyc(1);
      check("R8 pin flag at edge 32", status_o, 8'h60);
      ext_low = 1'b0;
      cyc(4);
      do_read(8'h60);
   endtask

   task automatic t_window_high;
      wdog_i = 1'b1;
      cyc(1);
      wdog_i = 1'b0;
      cyc(34);
      check("R8 pin high no flag", status_o, 8'h20);
      do_read(8'h20);
   endtask

   task automatic t_ext_only;
      ext_low = 1'b1;
      cyc(2);
      check("R9 not before edge 3", status_o, 8'h00);
      cyc(1);
      check("R9 pin flag", status_o, 8'h40);
      check("R9 no drive", {7'd0, rst_drive_o}, 8'h00);
      ext_low = 1'b0;
      cyc(4);
      do_read(8'h40);
   endtask

   initial begin
      t_por();
      t_sources();
      t_badaddr();
      t_accum();
      t_collide();
      t_window_low();
      t_window_high();
      t_ext_only();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule